// File: doc/BRIEF.md
# Redundant Result Checker with Table Reuse

This block sits at the writeback end of an execution pipeline that runs every instruction twice for fault detection. Each instruction is given a tag when it enters the tracker. The block then waits for two values for that tag: the result of the primary execution, and a reference value. The reference is either the result of a second, duplicate execution or a result taken from a lookup table of known instruction outcomes. When both values are present, the block compares them. A match commits the result on the writeback port. A mismatch raises a one-cycle error report instead.

When the table lookup for an instruction hits, no duplicate is issued. The primary result is checked against the table value. Because a table value is already trusted, a mismatch against it blames the unit that just produced the primary result, and the error report says so.

Two further modes change how the table is used:
- In reuse-only mode, a table hit skips execution altogether. The table value commits on the cycle after allocation.
- In memo mode, every verified result is also offered on a table-update port, so that a run-time table can learn it.

Top module: `rrc_checker`

## Requirements
- R1: Allocation hands out the lowest-numbered free tag. That tag is shown on `alloc_tag` in the same cycle. `alloc_ready` is high whenever any tag is free.
- R2: An instruction without a table hit commits only after both its primary and its duplicate result have arrived. The writeback appears the cycle after the later of the two is accepted.
- R3: The primary and duplicate results for a tag may arrive in either order or in the same cycle, with the same outcome.
- R4: When the two values are equal, the block pulses `wb_valid` for one cycle with the tag and the primary value, and frees the tag.
- R5: When the two values differ, the block pulses `err_valid` for one cycle with the tag, the primary value and the reference value, and `wb_valid` stays low. For a duplicate reference, `err_trusted` is 0.
- R6: For an instruction that hit the table (mode 00 or 10), the primary result is compared against the table value. A duplicate return for that tag is ignored. A mismatch reports `err_trusted` = 1.
- R7: In reuse-only mode (`mode` = 01), an instruction that hits the table commits the table value on the cycle after allocation, with no result returned. An instruction that misses still needs both results.
- R8: In memo mode (`mode` = 10), each successful commit also pulses `upd_valid`, with `upd_data` equal to the committed value. In every other mode, and on a mismatch, `upd_valid` stays low.
- R9: When several tags complete in the same cycle, they retire one per cycle, lowest tag first.
- R10: After reset, `wb_valid`, `err_valid` and `upd_valid` are low, `alloc_ready` is high and `alloc_tag` is 0.
- R11: When every tag is in use, `alloc_ready` is low and an `alloc_valid` request is ignored. No tag is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 00 check, 01 reuse-only, 10 memo, 11 treated as check |
| alloc_valid | input | 1 | Request to track a new instruction |
| alloc_hit | input | 1 | The table lookup for the instruction hit |
| alloc_tbl_data | input | DATA_W | Table result when `alloc_hit` is high |
| alloc_ready | output | 1 | At least one tag is free |
| alloc_tag | output | TAG_W | Tag granted to this request |
| prim_valid | input | 1 | Primary result return |
| prim_tag | input | TAG_W | Tag of the primary result |
| prim_data | input | DATA_W | Primary result value |
| dup_valid | input | 1 | Duplicate result return |
| dup_tag | input | TAG_W | Tag of the duplicate result |
| dup_data | input | DATA_W | Duplicate result value |
| wb_valid | output | 1 | Verified commit |
| wb_tag | output | TAG_W | Tag of the commit |
| wb_data | output | DATA_W | Committed value |
| err_valid | output | 1 | Mismatch report |
| err_tag | output | TAG_W | Tag of the mismatch |
| err_prim | output | DATA_W | Primary value that was compared |
| err_ref | output | DATA_W | Reference value that was compared |
| err_trusted | output | 1 | The reference came from the table |
| upd_valid | output | 1 | Table-update offer (memo mode) |
| upd_data | output | DATA_W | Verified value to store |

## Verification
The hardest case to reach from the ports is two tags completing on the same clock edge. The two result ports are each used once per cycle, and a completed tag otherwise retires on the very next edge. To get there, the bench:
1. Gives the lower tag its primary result first, leaving it waiting only for its duplicate.
2. Gives the higher tag a table hit.
3. In one cycle, sends the lower tag's duplicate and the higher tag's primary together.

The expected order of the two writebacks follows from tag order alone. The bench also covers a duplicate that arrives for a table-hit tag and must be dropped, and an allocation request made while the tracker is full.

// File: rtl/rrc_pkg.sv
package rrc_pkg;

  typedef enum logic [1:0] {
    MODE_CHECK = 2'b00,
    MODE_REUSE = 2'b01,
    MODE_MEMO  = 2'b10,
    MODE_RSVD  = 2'b11
  } rrc_mode_e;

  // A table hit skips execution only in reuse-only mode
  function automatic logic skips_exec(input logic [1:0] m, input logic hit);
    return hit && (m == MODE_REUSE);
  endfunction

  // Verified results are offered to the table only in memo mode
  function automatic logic offers_update(input logic [1:0] m);
    return m == MODE_MEMO;
  endfunction

endpackage

// File: rtl/rrc_pick.sv
module rrc_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             found,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  // Lowest set request wins: scan downward so the lowest index is written last
  always_comb begin
    idx   = '0;
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx   = IDX_W'(i);
        grant = N'(1) << i;
      end
    end
    found = |req;
  end

endmodule

// File: rtl/rrc_slot.sv
module rrc_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc_en,
  input  logic              alloc_hit,
  input  logic              alloc_skip,
  input  logic [DATA_W-1:0] alloc_data,
  input  logic              prim_en,
  input  logic [DATA_W-1:0] prim_data,
  input  logic              dup_en,
  input  logic [DATA_W-1:0] dup_data,
  input  logic              retire_en,
  output logic              busy_o,
  output logic              complete_o,
  output logic [DATA_W-1:0] prim_o,
  output logic [DATA_W-1:0] ref_o,
  output logic              trusted_o
);

  logic              busy_q, have_prim_q, have_ref_q, trusted_q;
  logic [DATA_W-1:0] prim_q, ref_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q      <= 1'b0;
      have_prim_q <= 1'b0;
      have_ref_q  <= 1'b0;
      trusted_q   <= 1'b0;
      prim_q      <= '0;
      ref_q       <= '0;
    end else if (alloc_en) begin
      busy_q      <= 1'b1;
      have_ref_q  <= alloc_hit;
      trusted_q   <= alloc_hit;
      ref_q       <= alloc_data;
      // skipped execution: the table value stands in for the primary
      have_prim_q <= alloc_skip;
      prim_q      <= alloc_skip ? alloc_data : '0;
    end else if (retire_en) begin
      busy_q      <= 1'b0;
      have_prim_q <= 1'b0;
      have_ref_q  <= 1'b0;
      trusted_q   <= 1'b0;
    end else if (busy_q) begin
      if (prim_en && !have_prim_q) begin
        have_prim_q <= 1'b1;
        prim_q      <= prim_data;
      end
      if (dup_en && !have_ref_q) begin
        have_ref_q <= 1'b1;
        ref_q      <= dup_data;
      end
    end
  end

  assign busy_o     = busy_q;
  assign complete_o = busy_q && have_prim_q && have_ref_q;
  assign prim_o     = prim_q;
  assign ref_o      = ref_q;
  assign trusted_o  = trusted_q;

  // R1: only a free slot may be allocated
  a_r1_alloc_free: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_en |-> !busy_q);
  // R2: a slot retires only with both values present
  a_r2_retire_complete: assert property (@(posedge clk) disable iff (!rst_n)
    retire_en |-> complete_o);
  // R7: a skipped instruction is complete on the next cycle
  a_r7_skip_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_en && alloc_skip) |=> complete_o);
  // R6: once a reference is held, later returns do not alter it
  a_r6_ref_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && have_ref_q && !retire_en && !alloc_en) |=> $stable(ref_q));

endmodule

// File: rtl/rrc_checker.sv
module rrc_checker #(
  parameter int NUM_TAGS = 4,
  parameter int DATA_W   = 32,
  localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              alloc_valid,
  input  logic              alloc_hit,
  input  logic [DATA_W-1:0] alloc_tbl_data,
  output logic              alloc_ready,
  output logic [TAG_W-1:0]  alloc_tag,
  input  logic              prim_valid,
  input  logic [TAG_W-1:0]  prim_tag,
  input  logic [DATA_W-1:0] prim_data,
  input  logic              dup_valid,
  input  logic [TAG_W-1:0]  dup_tag,
  input  logic [DATA_W-1:0] dup_data,
  output logic              wb_valid,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_data,
  output logic              err_valid,
  output logic [TAG_W-1:0]  err_tag,
  output logic [DATA_W-1:0] err_prim,
  output logic [DATA_W-1:0] err_ref,
  output logic              err_trusted,
  output logic              upd_valid,
  output logic [DATA_W-1:0] upd_data
);
  import rrc_pkg::*;

  function automatic logic vals_agree(input logic [DATA_W-1:0] a,
                                      input logic [DATA_W-1:0] b);
    return a == b;
  endfunction

  logic [NUM_TAGS-1:0] busy_vec, complete_vec, trusted_vec, ret_grant;
  logic [DATA_W-1:0]   slot_prim [NUM_TAGS];
  logic [DATA_W-1:0]   slot_ref  [NUM_TAGS];

  logic              alloc_fire, alloc_skip;
  logic              ret_fire, ret_match, sel_trusted;
  logic [TAG_W-1:0]  ret_idx;
  logic [DATA_W-1:0] sel_prim, sel_ref;
  logic [NUM_TAGS-1:0] free_grant;

  rrc_pick #(.N(NUM_TAGS), .IDX_W(TAG_W)) i_free_pick (
    .req(~busy_vec), .found(alloc_ready), .idx(alloc_tag), .grant(free_grant)
  );

  rrc_pick #(.N(NUM_TAGS), .IDX_W(TAG_W)) i_ret_pick (
    .req(complete_vec), .found(ret_fire), .idx(ret_idx), .grant(ret_grant)
  );

  assign alloc_fire = alloc_valid && alloc_ready;
  assign alloc_skip = skips_exec(mode, alloc_hit);

  for (genvar g = 0; g < NUM_TAGS; g++) begin : g_slot
    rrc_slot #(.DATA_W(DATA_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc_en  (alloc_fire && free_grant[g]),
      .alloc_hit (alloc_hit),
      .alloc_skip(alloc_skip),
      .alloc_data(alloc_tbl_data),
      .prim_en   (prim_valid && (prim_tag == TAG_W'(g))),
      .prim_data (prim_data),
      .dup_en    (dup_valid && (dup_tag == TAG_W'(g))),
      .dup_data  (dup_data),
      .retire_en (ret_grant[g]),
      .busy_o    (busy_vec[g]),
      .complete_o(complete_vec[g]),
      .prim_o    (slot_prim[g]),
      .ref_o     (slot_ref[g]),
      .trusted_o (trusted_vec[g])
    );
  end

  assign sel_prim    = slot_prim[ret_idx];
  assign sel_ref     = slot_ref[ret_idx];
  assign sel_trusted = trusted_vec[ret_idx];
  assign ret_match   = vals_agree(sel_prim, sel_ref);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_valid    <= 1'b0;
      wb_tag      <= '0;
      wb_data     <= '0;
      err_valid   <= 1'b0;
      err_tag     <= '0;
      err_prim    <= '0;
      err_ref     <= '0;
      err_trusted <= 1'b0;
      upd_valid   <= 1'b0;
      upd_data    <= '0;
    end else begin
      wb_valid    <= ret_fire && ret_match;
      wb_tag      <= ret_idx;
      wb_data     <= sel_prim;
      err_valid   <= ret_fire && !ret_match;
      err_tag     <= ret_idx;
      err_prim    <= sel_prim;
      err_ref     <= sel_ref;
      err_trusted <= sel_trusted;
      upd_valid   <= ret_fire && ret_match && offers_update(mode);
      upd_data    <= sel_prim;
    end
  end

  // R4: a commit and an error never share a cycle
  a_r4_wb_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && err_valid));
  // R8: a table update accompanies a commit with the same value
  a_r8_upd_with_wb: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid |-> (wb_valid && upd_data == wb_data));
  // R9: at most one tag retires per cycle
  a_r9_single_retire: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ret_grant));
  // R5: the same tag cannot report an error on two cycles in a row
  a_r5_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    err_valid |=> (!err_valid || err_tag != $past(err_tag)));

endmodule

// File: tb/test_rrc_checker.sv
module test_rrc_checker;
  localparam int CLK_PERIOD = 10;
  localparam int NT = 4;
  localparam int DW = 32;
  localparam int TW = 2;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    mode;
  logic          alloc_valid, alloc_hit;
  logic [DW-1:0] alloc_tbl_data;
  logic          alloc_ready;
  logic [TW-1:0] alloc_tag;
  logic          prim_valid, dup_valid;
  logic [TW-1:0] prim_tag, dup_tag;
  logic [DW-1:0] prim_data, dup_data;
  logic          wb_valid, err_valid, err_trusted, upd_valid;
  logic [TW-1:0] wb_tag, err_tag;
  logic [DW-1:0] wb_data, err_prim, err_ref, upd_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rrc_checker #(.NUM_TAGS(NT), .DATA_W(DW)) i_rrc_checker (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .alloc_valid(alloc_valid), .alloc_hit(alloc_hit), .alloc_tbl_data(alloc_tbl_data),
    .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .prim_valid(prim_valid), .prim_tag(prim_tag), .prim_data(prim_data),
    .dup_valid(dup_valid), .dup_tag(dup_tag), .dup_data(dup_data),
    .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_data(wb_data),
    .err_valid(err_valid), .err_tag(err_tag), .err_prim(err_prim), .err_ref(err_ref),
    .err_trusted(err_trusted), .upd_valid(upd_valid), .upd_data(upd_data)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic [1:0] m);
    @(negedge clk);
    rst_n = 1'b0; mode = m;
    alloc_valid = 0; alloc_hit = 0; alloc_tbl_data = '0;
    prim_valid = 0; prim_tag = '0; prim_data = '0;
    dup_valid = 0; dup_tag = '0; dup_data = '0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
  endtask

  task automatic do_alloc(input bit hit, input logic [DW-1:0] tbl, output int tag);
    alloc_valid = 1; alloc_hit = hit; alloc_tbl_data = tbl;
    #1;
    tag = int'(alloc_tag);
    tick();
    alloc_valid = 0; alloc_hit = 0;
  endtask

  task automatic send(input bit p, input int pt, input logic [DW-1:0] pd,
                      input bit d, input int dt, input logic [DW-1:0] dd);
    prim_valid = p; prim_tag = TW'(pt); prim_data = pd;
    dup_valid  = d; dup_tag  = TW'(dt); dup_data  = dd;
    tick();
    prim_valid = 0; dup_valid = 0;
  endtask

  task automatic expect_wb(input string req, input int tag, input logic [DW-1:0] d);
    chk(wb_valid == 1'b1, req, wb_valid, 1);
    chk(wb_tag == TW'(tag), req, wb_tag, tag);
    chk(wb_data == d, req, wb_data, d);
    chk(err_valid == 1'b0, req, err_valid, 0);
  endtask

  task automatic t_reset();
    do_reset(2'b00);
    chk(wb_valid == 0 && err_valid == 0 && upd_valid == 0, "R10", {wb_valid, err_valid, upd_valid}, 0);
    chk(alloc_ready == 1, "R10", alloc_ready, 1);
    chk(alloc_tag == 0, "R10", alloc_tag, 0);
  endtask

  task automatic t_dup_order();
    int t;
    do_reset(2'b00);
    do_alloc(0, '0, t);
    chk(t == 0, "R1", t, 0);
    send(1, t, 32'h1111, 0, 0, '0);
    tick();
    chk(wb_valid == 0 && err_valid == 0, "R2", wb_valid, 0);
    send(0, 0, '0, 1, t, 32'h1111);
    tick();
    expect_wb("R4", t, 32'h1111);
    tick();
    chk(wb_valid == 0, "R4", wb_valid, 0);
    // reverse order
    do_alloc(0, '0, t);
    send(0, 0, '0, 1, t, 32'h2222);
    send(1, t, 32'h2222, 0, 0, '0);
    tick();
    expect_wb("R3", t, 32'h2222);
    // same cycle
    do_alloc(0, '0, t);
    send(1, t, 32'h3333, 1, t, 32'h3333);
    tick();
    expect_wb("R3", t, 32'h3333);
  endtask

  task automatic t_mismatch();
    int t;
    do_reset(2'b00);
    do_alloc(0, '0, t);
    send(1, t, 32'hAAAA, 1, t, 32'hBBBB);
    tick();
    chk(err_valid == 1, "R5", err_valid, 1);
    chk(err_tag == TW'(t), "R5", err_tag, t);
    chk(err_prim == 32'hAAAA, "R5", err_prim, 32'hAAAA);
    chk(err_ref == 32'hBBBB, "R5", err_ref, 32'hBBBB);
    chk(err_trusted == 0, "R5", err_trusted, 0);
    chk(wb_valid == 0, "R5", wb_valid, 0);
    tick();
    chk(err_valid == 0, "R5", err_valid, 0);
  endtask

  task automatic t_hit();
    int t;
    do_reset(2'b00);
    do_alloc(1, 32'h55, t);
    send(0, 0, '0, 1, t, 32'h99);
    tick();
    chk(wb_valid == 0 && err_valid == 0, "R6", {wb_valid, err_valid}, 0);
    send(1, t, 32'h55, 0, 0, '0);
    tick();
    expect_wb("R6", t, 32'h55);
    do_alloc(1, 32'h10, t);
    send(1, t, 32'h11, 0, 0, '0);
    tick();
    chk(err_valid == 1, "R6", err_valid, 1);
    chk(err_trusted == 1, "R6", err_trusted, 1);
    chk(err_ref == 32'h10, "R6", err_ref, 32'h10);
  endtask

  task automatic t_reuse();
    int t;
    do_reset(2'b01);
    do_alloc(1, 32'h77, t);
    tick();
    expect_wb("R7", t, 32'h77);
    chk(upd_valid == 0, "R8", upd_valid, 0);
    do_alloc(0, '0, t);
    tick();
    chk(wb_valid == 0, "R7", wb_valid, 0);
    send(1, t, 32'h88, 1, t, 32'h88);
    tick();
    expect_wb("R7", t, 32'h88);
  endtask

  task automatic t_memo();
    int t;
    do_reset(2'b10);
    do_alloc(0, '0, t);
    send(1, t, 32'hABC, 1, t, 32'hABC);
    tick();
    expect_wb("R8", t, 32'hABC);
    chk(upd_valid == 1, "R8", upd_valid, 1);
    chk(upd_data == 32'hABC, "R8", upd_data, 32'hABC);
    do_alloc(0, '0, t);
    send(1, t, 32'h1, 1, t, 32'h2);
    tick();
    chk(upd_valid == 0, "R8", upd_valid, 0);
  endtask

  task automatic t_full();
    int t;
    do_reset(2'b00);
    for (int i = 0; i < NT; i++) begin
      do_alloc(0, '0, t);
      chk(t == i, "R1", t, i);
    end
    chk(alloc_ready == 0, "R11", alloc_ready, 0);
    alloc_valid = 1;
    tick();
    alloc_valid = 0;
    send(1, 1, 32'h5, 1, 1, 32'h5);
    tick();
    expect_wb("R4", 1, 32'h5);
    chk(alloc_ready == 1, "R11", alloc_ready, 1);
    chk(alloc_tag == 1, "R11", alloc_tag, 1);
  endtask

  task automatic t_priority();
    int t0, t1;
    do_reset(2'b00);
    do_alloc(0, '0, t0);
    do_alloc(1, 32'h44, t1);
    send(1, t0, 32'h33, 0, 0, '0);
    send(1, t1, 32'h44, 1, t0, 32'h33);
    tick();
    expect_wb("R9", t0, 32'h33);
    tick();
    expect_wb("R9", t1, 32'h44);
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_dup_order();
    t_mismatch();
    t_hit();
    t_reuse();
    t_memo();
    t_full();
    t_priority();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule